// File: doc/BRIEF.md
# Programmable Supervisory Watchdog Timer

This block supervises a processor by expecting a sign of life within a programmed window. The window length is the product of a five-bit multiplier and one of four resolutions, all counted in ticks of a 1/16 s timebase enable that the chip derives from its 32.768 kHz reference. The software keeps the watchdog quiet either by toggling a dedicated kick pin, where both edges count, or by writing the watchdog configuration register. A multiplier of zero switches the function off.

When the window expires, a watchdog flag is set. A steering bit picks the consequence. With steering clear, an interrupt request is latched until software writes zero to the register. With steering set, an active-low reset pulse of a fixed number of timebase ticks is emitted, the configuration register is cleared, and a one-cycle clear strobe tells neighbouring logic to drop its alarm-enable, backup-alarm-enable and frequency-test bits. Reading the flag register clears the flag. A power-down indication clears the configuration and the interrupt, and blocks register writes while it stays high.

Top module: `wdog_supervisor`

## Requirements
- R1: The configuration byte places the steering bit in bit 7, the multiplier in bits 6..2 and the resolution code in bits 1..0; `cfg_value` shows the byte currently held.
- R2: The resolution codes 00, 01, 10 and 11 stand for 1, 4, 16 and 64 timebase ticks; the timeout in ticks is multiplier times resolution, so writing 0x0E times out on the 48th tick after the write.
- R3: Either a rising or a falling edge on `kick_pin`, seen after a two-stage synchronizer, restarts the count, and so does any register write; with regular kicks no timeout occurs.
- R4: On timeout `wd_flag` is set, and with the steering bit clear `irq` goes high and stays high.
- R5: On timeout with the steering bit set, `rst_out_n` goes low in the same cycle as the flag, stays low until the RST_TICKS-th tick after the timeout tick, the configuration byte becomes 0x00 and `ctl_clear` pulses high for one cycle.
- R6: Writing 0x00 releases `irq` and disables counting; a nonzero write leaves a latched `irq` high; a `flag_rd` pulse clears `wd_flag` unless a timeout occurs in the same cycle.
- R7: After reset the configuration is 0x00, `irq` and `wd_flag` are low and `rst_out_n` is high; while `pwr_down` is high the configuration reads 0x00, `irq` is low, writes are ignored, and `wd_flag` keeps its value.
- R8: With a multiplier of zero no timeout occurs, whatever the resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (initial power-up) |
| tick_16th | input | 1 | One-cycle enable every 1/16 s |
| kick_pin | input | 1 | Asynchronous kick input, both edges restart |
| pwr_down | input | 1 | Supply out of tolerance |
| reg_wr | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 8 | Write data for the configuration register |
| flag_rd | input | 1 | Read strobe of the flag register |
| irq | output | 1 | Latched interrupt request |
| rst_out_n | output | 1 | Active-low reset pulse |
| wd_flag | output | 1 | Watchdog timeout flag |
| ctl_clear | output | 1 | One-cycle strobe clearing neighbouring control bits |
| cfg_value | output | 8 | Configuration byte currently held |

## Verification
The bench keeps the multiplier and resolution widths at their defaults, so the full 1 to 1984 tick range, including the longest 31 × 64 tick window, is exercised, while the timebase enable fires every fourth clock so that even the longest window ends within a few thousand cycles. RST_TICKS is raised to 3, so the length of the reset pulse is told apart from a one- or two-tick pulse, and the synchronizer latency on the kick pin is modelled exactly, which lets the pin kicks be compared cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Configuration byte layout: steering, multiplier, resolution code.
    typedef struct packed {
        logic       steer;
        logic [4:0] mult;
        logic [1:0] res;
    } wd_cfg_t;

    localparam int MULT_W        = 5;
    localparam int RES_W         = 2;
    // Each resolution step multiplies the tick count by 2**RES_STEP_LOG2.
    localparam int RES_STEP_LOG2 = 2;
    localparam int MAX_LIMIT     = ((1 << MULT_W) - 1) *
                                   (1 << (RES_STEP_LOG2 * ((1 << RES_W) - 1)));
    localparam int CNT_W         = $clog2(MAX_LIMIT + 1);

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_seen
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] chain;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[LEN-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Any change between the last synchronized stage and its history bit.
    assign edge_seen = s_q.chain[LEN-1] ^ s_q.chain[LEN-2];

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t t_q, t_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             armed;

    always_comb begin
        cnt_inc = t_q.cnt + 1'b1;
        armed   = (limit != '0);
        expire  = tick && armed && !restart && (cnt_inc == limit);
        t_d     = t_q;
        if (restart || !armed) begin
            t_d.cnt = '0;
        end else if (tick) begin
            t_d.cnt = expire ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic active
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic          on;
        logic [PW-1:0] cnt;
    } pulse_t;

    pulse_t p_q, p_d;
    logic [PW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = p_q.cnt + 1'b1;
        p_d     = p_q;
        if (start) begin
            p_d.on  = 1'b1;
            p_d.cnt = '0;
        end else if (p_q.on && tick) begin
            if (cnt_inc == PW'(PULSE_TICKS)) begin
                p_d.on  = 1'b0;
                p_d.cnt = '0;
            end else begin
                p_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active = p_q.on;

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int RST_TICKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16th,
    input  logic       kick_pin,
    input  logic       pwr_down,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       flag_rd,
    output logic       irq,
    output logic       rst_out_n,
    output logic       wd_flag,
    output logic       ctl_clear,
    output logic [7:0] cfg_value
);
    typedef struct packed {
        wd_cfg_t cfg;
        logic    irq;
        logic    flag;
        logic    clr;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             pin_edge;
    logic             wr_ok;
    logic             restart;
    logic             expire;
    logic             pulse_on;
    logic [CNT_W-1:0] limit;

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (kick_pin),
        .edge_seen (pin_edge)
    );

    // Timeout in ticks: multiplier shifted by the resolution step.
    always_comb begin
        limit = CNT_W'(c_q.cfg.mult) << (RES_STEP_LOG2 * int'(c_q.cfg.res));
    end

    assign wr_ok   = reg_wr && !pwr_down;
    assign restart = pin_edge || wr_ok || pwr_down;

    wdog_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_16th),
        .restart (restart),
        .limit   (limit),
        .expire  (expire)
    );

    wdog_rst_pulse #(.PULSE_TICKS(RST_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_16th),
        .start  (expire && c_q.cfg.steer),
        .active (pulse_on)
    );

    always_comb begin
        c_d     = c_q;
        c_d.clr = expire && c_q.cfg.steer;

        if (pwr_down) begin
            c_d.cfg = '0;
        end else if (expire && c_q.cfg.steer) begin
            c_d.cfg = '0;
        end else if (reg_wr) begin
            c_d.cfg = wd_cfg_t'(reg_wdata);
        end

        if (pwr_down) begin
            c_d.irq = 1'b0;
        end else if (reg_wr && reg_wdata == 8'h00) begin
            c_d.irq = 1'b0;
        end else if (expire && !c_q.cfg.steer) begin
            c_d.irq = 1'b1;
        end

        if (expire) begin
            c_d.flag = 1'b1;
        end else if (flag_rd) begin
            c_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq       = c_q.irq;
    assign wd_flag   = c_q.flag;
    assign ctl_clear = c_q.clr;
    assign cfg_value = c_q.cfg;
    assign rst_out_n = !pulse_on;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_16th,
    input logic       kick_pin,
    input logic       pwr_down,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       flag_rd,
    input logic       irq,
    input logic       rst_out_n,
    input logic       wd_flag,
    input logic       ctl_clear,
    input logic [7:0] cfg_value
);
    // R4
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> wd_flag);

    // R5
    pulse_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> (cfg_value == 8'h00) && wd_flag && ctl_clear);

    // R5
    clear_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clear |-> !rst_out_n);

    // R6
    zero_write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata == 8'h00 && !pwr_down) |=> !irq);

    // R7
    pwr_down_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (cfg_value == 8'h00) && !irq);

    // R8
    zero_mult_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> ($past(cfg_value[6:2]) != 5'd0));

endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (.*);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;

    localparam int RSTT = 3;
    localparam int TICK_GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16th = 1'b0;
    logic       kick_pin = 1'b0;
    logic       pwr_down = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic       irq, rst_out_n, wd_flag, ctl_clear;
    logic [7:0] cfg_value;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tcnt = 0;

    wdog_supervisor #(.RST_TICKS(RSTT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_16th(tick_16th), .kick_pin(kick_pin),
        .pwr_down(pwr_down), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .flag_rd(flag_rd), .irq(irq), .rst_out_n(rst_out_n), .wd_flag(wd_flag),
        .ctl_clear(ctl_clear), .cfg_value(cfg_value)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Timebase enable every TICK_GAP clocks.
    always @(negedge clk) begin
        cyc++;
        tick_16th <= (cyc % TICK_GAP == 0);
    end
    always @(posedge clk) if (tick_16th) tcnt++;

    // Behavioural reference model.
    int m_cfg, m_irq, m_flag, m_clr, m_cnt, m_act, m_pc;
    int kq[$];
    always @(posedge clk) begin
        int edge_k, kick, clr_c, lim, expd, mult, res, steer;
        if (!rst_n) begin
            m_cfg = 0; m_irq = 0; m_flag = 0; m_clr = 0; m_cnt = 0;
            m_act = 0; m_pc = 0;
            kq = '{0, 0, 0};
        end else begin
            edge_k = (kq[1] != kq[2]);
            kq.push_front(int'(kick_pin));
            void'(kq.pop_back());
            steer = (m_cfg >> 7) & 1;
            mult  = (m_cfg >> 2) & 31;
            res   = m_cfg & 3;
            lim   = mult << (2 * res);
            kick  = edge_k || (reg_wr && !pwr_down);
            clr_c = kick || pwr_down;
            expd  = tick_16th && !clr_c && lim != 0 && (m_cnt + 1 == lim);
            if (clr_c || lim == 0) m_cnt = 0;
            else if (tick_16th) m_cnt = expd ? 0 : m_cnt + 1;
            if (expd && steer) begin m_act = 1; m_pc = 0; end
            else if (m_act && tick_16th) begin
                if (m_pc + 1 == RSTT) begin m_act = 0; m_pc = 0; end
                else m_pc++;
            end
            m_clr = expd && steer;
            if (pwr_down) m_irq = 0;
            else if (reg_wr && reg_wdata == 0) m_irq = 0;
            else if (expd && !steer) m_irq = 1;
            if (pwr_down) m_cfg = 0;
            else if (expd && steer) m_cfg = 0;
            else if (reg_wr) m_cfg = int'(reg_wdata);
            if (expd) m_flag = 1;
            else if (flag_rd) m_flag = 0;
        end
    end

    // Cycle-by-cycle comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 irq", int'(irq), m_irq);
            chk("R4 wd_flag", int'(wd_flag), m_flag);
            chk("R5 rst_out_n", int'(rst_out_n), m_act ? 0 : 1);
            chk("R5 ctl_clear", int'(ctl_clear), m_clr);
            chk("R1 cfg_value", int'(cfg_value), m_cfg);
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_flag();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    task automatic wait_flag(input int cap);
        for (int i = 0; i < cap && !wd_flag; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int t0;
        bit done;
        done = 0;
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
            begin
                idle(3);
                // R7: reset state
                chk("R7 reset cfg", int'(cfg_value), 0);
                chk("R7 reset irq", int'(irq), 0);
                chk("R7 reset flag", int'(wd_flag), 0);
                chk("R7 reset rst_out_n", int'(rst_out_n), 1);
                @(negedge clk); rst_n = 1'b1;
                idle(5);

                // R2: 0x0E -> 3 x 16 ticks, interrupt steering
                wr(8'h0E); t0 = tcnt;
                chk("R1 cfg readback", int'(cfg_value), 8'h0E);
                wait_flag(2000);
                chk("R2 timeout ticks", tcnt - t0, 48);
                chk("R4 irq latched", int'(irq), 1);
                chk("R4 no reset pulse", int'(rst_out_n), 1);

                // R6: flag read, nonzero write keeps irq, zero write releases
                rd_flag();
                chk("R6 flag cleared by read", int'(wd_flag), 0);
                chk("R6 irq kept after read", int'(irq), 1);
                wr(8'h0D);
                chk("R6 irq kept on nonzero write", int'(irq), 1);
                wr(8'h00);
                chk("R6 irq released", int'(irq), 0);
                chk("R6 disabled cfg", int'(cfg_value), 0);

                // R3: pin edges keep a 5-tick window alive
                wr(8'h14);
                for (int k = 0; k < 10; k++) begin
                    idle(3 * TICK_GAP);
                    kick_pin = ~kick_pin;
                end
                chk("R3 pin kicks prevent timeout", int'(wd_flag), 0);
                for (int k = 0; k < 6; k++) begin
                    idle(3 * TICK_GAP);
                    wr(8'h14);
                end
                chk("R3 write kicks prevent timeout", int'(wd_flag), 0);
                t0 = tcnt;
                wait_flag(200);
                chk("R3 free run after last kick", tcnt - t0, 5);
                wr(8'h00); rd_flag();

                // R8: zero multiplier never times out
                wr(8'h03);
                idle(400);
                chk("R8 zero multiplier flag", int'(wd_flag), 0);
                chk("R8 zero multiplier irq", int'(irq), 0);

                // R5: reset steering, 2-tick window
                wr(8'h88); t0 = tcnt;
                wait_flag(200);
                chk("R5 reset window ticks", tcnt - t0, 2);
                chk("R5 pulse low", int'(rst_out_n), 0);
                chk("R5 cfg cleared", int'(cfg_value), 0);
                chk("R5 ctl_clear strobe", int'(ctl_clear), 1);
                chk("R5 no irq", int'(irq), 0);
                t0 = tcnt;
                @(negedge clk);
                chk("R5 strobe one cycle", int'(ctl_clear), 0);
                for (int i = 0; i < 200 && !rst_out_n; i++) @(negedge clk);
                chk("R5 pulse length ticks", tcnt - t0, RSTT);
                rd_flag();

                // R7: power-down
                wr(8'h04);
                wait_flag(200);
                chk("R4 short window irq", int'(irq), 1);
                @(negedge clk); pwr_down = 1'b1;
                @(negedge clk);
                chk("R7 pd irq low", int'(irq), 0);
                chk("R7 pd cfg cleared", int'(cfg_value), 0);
                chk("R7 pd flag kept", int'(wd_flag), 1);
                wr(8'h0E);
                chk("R7 pd write ignored", int'(cfg_value), 0);
                @(negedge clk); pwr_down = 1'b0;
                idle(2);
                chk("R7 after pd cfg", int'(cfg_value), 0);
                rd_flag();

                // R2: longest window, 31 x 64 ticks
                wr(8'h7F); t0 = tcnt;
                wait_flag(9000);
                chk("R2 longest window ticks", tcnt - t0, 1984);
                wr(8'h00);
                idle(10);
            end
        join_any
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule